// File: doc/BRIEF.md
# Supervisory Brake Fallback Controller

This block supervises the brake actuator of a vehicle whose high-level decisions come from a host computer that cannot promise a response time. A local obstacle-detect pulse does not apply the brakes by itself. It opens a confirmation window of fixed length, 20 ms by default, and the block waits for the host to return a verdict. A stop verdict (code 1) inside the window applies full braking. A clear verdict (code 0) inside the window sends the vehicle back to normal driving.

If the window runs out with no verdict, the block does not apply full braking. It enters a stabilization state with gentle braking and hazard lights on. It leaves that state when a late host verdict arrives. It escalates to full braking when the obstacle is reported inside the critical zone. Full braking ends only on a clear verdict from the host or on reset.

There are four states: NORMAL, CONFIRM, STABILIZE and FULL. The transitions are:
- detect (NORMAL→CONFIRM)
- confirm-stop (CONFIRM→FULL)
- confirm-clear (CONFIRM→NORMAL)
- window-expire (CONFIRM→STABILIZE)
- late-stop (STABILIZE→FULL)
- late-continue (STABILIZE→NORMAL)
- critical-escalate (STABILIZE→FULL)
- release (FULL→NORMAL)

Synchronous reset returns the block to NORMAL from any state.

Top module: `brk_supervisor`

## Requirements
- R1: A detect pulse in NORMAL moves the block to CONFIRM on the next clock edge. CONFIRM drives brake level 00 (none) with hazard on.
- R2: A verdict with valid high and code 1 (stop) during CONFIRM moves the block to FULL on the next edge. FULL drives brake level 10 with hazard on.
- R3: A verdict with valid high and code 0 (clear) during CONFIRM returns the block to NORMAL on the next edge. NORMAL drives brake level 00 with hazard off.
- R4: With no verdict, CONFIRM lasts exactly WIN_CYCLES clock cycles and then moves to STABILIZE. STABILIZE drives brake level 01 with hazard on. A verdict in the last window cycle is still honoured.
- R5: In STABILIZE, the critical-zone flag with no verdict present moves the block to FULL on the next edge.
- R6: In STABILIZE, a stop verdict (code 1) moves the block to FULL on the next edge.
- R7: In STABILIZE, a continue verdict (code 0) returns the block to NORMAL on the next edge. The verdict takes priority over the critical-zone flag in the same cycle.
- R8: In NORMAL, verdicts and the critical-zone flag are ignored, and the outputs stay at 00 with hazard off.
- R9: A detect pulse in CONFIRM, STABILIZE or FULL neither restarts the window nor changes the state.
- R10: FULL is left only on a clear verdict (code 0). A stop verdict, the critical-zone flag or a detect pulse keeps the block in FULL.
- R11: Synchronous reset, active high, puts the block in NORMAL with brake level 00 and hazard off on the next edge.
- R12: WIN_CYCLES equals CLK_HZ / 1000 × WINDOW_MS. With the default 100 MHz clock this is 20 ms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| detect_i | input | 1 | Local obstacle-detect pulse |
| verdict_valid_i | input | 1 | Host verdict present this cycle |
| verdict_code_i | input | 1 | Host verdict: 1 stop/brake, 0 clear/continue |
| critical_i | input | 1 | Obstacle is inside the critical zone |
| brake_lvl_o | output | 2 | Brake level: 00 none, 01 gentle, 10 full |
| hazard_o | output | 1 | Hazard lights |

## Verification
The bench measures the window to the exact cycle. A design off by one would show STABILIZE one cycle early or late, or would drop a verdict that arrives in the final window cycle. It drives the critical-zone flag together with a continue verdict in STABILIZE. A design with the priority reversed would brake fully where the vehicle should return to normal. It repeats detect pulses during a window and while braking. A design that restarts the timer would reach STABILIZE late, and one that re-enters CONFIRM would release a full brake. Seeded random traffic, including resets in mid-sequence, is compared cycle by cycle against a reference model held in the bench.

// File: rtl/brk_pkg.sv
package brk_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL    = 2'd0,
        ST_CONFIRM   = 2'd1,
        ST_STABILIZE = 2'd2,
        ST_FULL      = 2'd3
    } sup_state_t;

    typedef enum logic [1:0] {
        BRK_NONE   = 2'b00,
        BRK_GENTLE = 2'b01,
        BRK_FULL   = 2'b10
    } brk_lvl_t;

    localparam logic VERDICT_STOP  = 1'b1;
    localparam logic VERDICT_CLEAR = 1'b0;

endpackage

// File: rtl/brk_window_timer.sv
module brk_window_timer #(
    parameter int unsigned WIN_CYCLES = 2_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic expired_o
);
    localparam int unsigned CW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign expired_o = run_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run_i || expired_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4: once the window expires the state machine must stop running the timer
    a_r4_expire_ends_window: assert property (@(posedge clk) disable iff (rst)
        expired_o |=> !run_i);

endmodule

// File: rtl/brk_fsm.sv
module brk_fsm
    import brk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       detect_i,
    input  logic       verdict_valid_i,
    input  logic       verdict_code_i,
    input  logic       critical_i,
    input  logic       expired_i,
    output sup_state_t state_o
);
    sup_state_t state_q;
    sup_state_t state_d;

    logic v_stop;
    logic v_clear;

    assign v_stop  = verdict_valid_i && (verdict_code_i == VERDICT_STOP);
    assign v_clear = verdict_valid_i && (verdict_code_i == VERDICT_CLEAR);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_NORMAL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORMAL: begin
                if (detect_i) state_d = ST_CONFIRM;
            end
            ST_CONFIRM: begin
                if (v_stop)         state_d = ST_FULL;
                else if (v_clear)   state_d = ST_NORMAL;
                else if (expired_i) state_d = ST_STABILIZE;
            end
            ST_STABILIZE: begin
                if (v_stop)          state_d = ST_FULL;
                else if (v_clear)    state_d = ST_NORMAL;
                else if (critical_i) state_d = ST_FULL;
            end
            ST_FULL: begin
                if (v_clear) state_d = ST_NORMAL;
            end
            default: state_d = ST_NORMAL;
        endcase
    end

    assign state_o = state_q;

    a_r2_confirm_stop: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CONFIRM && v_stop) |=> state_q == ST_FULL);

    a_r5_critical_escalate: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STABILIZE && !verdict_valid_i && critical_i) |=> state_q == ST_FULL);

    a_r8_idle_ignores: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_NORMAL && !detect_i) |=> state_q == ST_NORMAL);

    a_r10_full_holds: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FULL && !v_clear) |=> state_q == ST_FULL);

endmodule

// File: rtl/brk_out_decode.sv
module brk_out_decode
    import brk_pkg::*;
(
    input  sup_state_t state_i,
    output brk_lvl_t   lvl_o,
    output logic       hazard_o
);
    always_comb begin
        lvl_o    = BRK_NONE;
        hazard_o = 1'b1;
        unique case (state_i)
            ST_NORMAL: begin
                lvl_o    = BRK_NONE;
                hazard_o = 1'b0;
            end
            ST_CONFIRM:   lvl_o = BRK_NONE;
            ST_STABILIZE: lvl_o = BRK_GENTLE;
            ST_FULL:      lvl_o = BRK_FULL;
            default: begin
                lvl_o    = BRK_NONE;
                hazard_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/brk_supervisor.sv
module brk_supervisor
    import brk_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 100_000_000,
    parameter int unsigned WINDOW_MS = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       detect_i,
    input  logic       verdict_valid_i,
    input  logic       verdict_code_i,
    input  logic       critical_i,
    output logic [1:0] brake_lvl_o,
    output logic       hazard_o
);
    // R12: window length in cycles derived from clock rate
    localparam int unsigned WIN_CYCLES = (CLK_HZ / 1000) * WINDOW_MS;

    sup_state_t state;
    brk_lvl_t   lvl;
    logic       expired;
    logic       run;

    assign run = (state == ST_CONFIRM);

    brk_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run_i    (run),
        .expired_o(expired)
    );

    brk_fsm u_fsm (
        .clk            (clk),
        .rst            (rst),
        .detect_i       (detect_i),
        .verdict_valid_i(verdict_valid_i),
        .verdict_code_i (verdict_code_i),
        .critical_i     (critical_i),
        .expired_i      (expired),
        .state_o        (state)
    );

    brk_out_decode u_dec (
        .state_i (state),
        .lvl_o   (lvl),
        .hazard_o(hazard_o)
    );

    assign brake_lvl_o = lvl;

    a_r11_reset_release: assert property (@(posedge clk)
        rst |=> (brake_lvl_o == 2'b00 && !hazard_o));

    a_r1_no_brake_on_detect: assert property (@(posedge clk) disable iff (rst)
        (brake_lvl_o == 2'b00 && !hazard_o && detect_i) |=> (brake_lvl_o == 2'b00 && hazard_o));

    a_r7_continue_wins: assert property (@(posedge clk) disable iff (rst)
        (brake_lvl_o == 2'b01 && verdict_valid_i && !verdict_code_i) |=> (brake_lvl_o == 2'b00 && !hazard_o));

    a_r2_level_legal: assert property (@(posedge clk) disable iff (rst)
        brake_lvl_o != 2'b11);

endmodule

// File: tb/sim_brk_supervisor.sv
module sim_brk_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 1000;
    localparam int WINDOW_MS  = 20;
    localparam int WIN        = (CLK_HZ / 1000) * WINDOW_MS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic detect = 1'b0, vv = 1'b0, vc = 1'b0, crit = 1'b0;
    logic [1:0] lvl;
    logic haz;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench reference model: 0 normal, 1 confirm, 2 stabilize, 3 full
    int mst = 0;
    int mcnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brk_supervisor #(.CLK_HZ(CLK_HZ), .WINDOW_MS(WINDOW_MS)) u0 (
        .clk(clk), .rst(rst), .detect_i(detect), .verdict_valid_i(vv),
        .verdict_code_i(vc), .critical_i(crit), .brake_lvl_o(lvl), .hazard_o(haz)
    );

    function automatic logic [1:0] exp_lvl(int s);
        case (s)
            2: return 2'b01;
            3: return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic exp_haz(int s);
        return s != 0;
    endfunction

    task automatic model_update();
        if (rst) begin
            mst = 0; mcnt = 0;
        end else begin
            case (mst)
                0: if (detect) begin mst = 1; mcnt = 0; end
                1: begin
                    if (vv) mst = vc ? 3 : 0;
                    else if (mcnt == WIN - 1) mst = 2;
                    else mcnt++;
                end
                2: begin
                    if (vv) mst = vc ? 3 : 0;
                    else if (crit) mst = 3;
                end
                default: if (vv && !vc) mst = 0;
            endcase
            if (mst != 1) mcnt = 0;
        end
    endtask

    task automatic check(string tag);
        checks++;
        if (lvl !== exp_lvl(mst) || haz !== exp_haz(mst)) begin
            errors++;
            $display("FAIL %s: lvl=%b haz=%b expected lvl=%b haz=%b", tag, lvl, haz,
                     exp_lvl(mst), exp_haz(mst));
        end
    endtask

    task automatic step(logic r, logic d, logic v, logic c, logic k, string tag);
        rst = r; detect = d; vv = v; vc = c; crit = k;
        @(posedge clk);
        model_update();
        @(negedge clk);
        check(tag);
    endtask

    task automatic idle(string tag);
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    function automatic string tag_of(int s);
        case (s)
            0: return "R8";
            1: return "R1";
            2: return "R4";
            default: return "R10";
        endcase
    endfunction

    initial begin
        int conf_cycles;
        void'($urandom(32'd4242));
        @(negedge clk);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R11");
        // R8: verdicts and critical flag in normal are ignored
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R8");
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
        // R1 then R2
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
        idle("R1");
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R2");
        // R10: stop, critical, detect keep full
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R10");
        idle("R10");
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R10");
        // R3
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
        // R4 / R12: exact window length, detect mid-window (R9)
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
        conf_cycles = 1;
        for (int i = 0; i < WIN + 2; i++) begin
            step(1'b0, (i == 5), 1'b0, 1'b0, 1'b0, (i == 5) ? "R9" : "R4");
            if (lvl == 2'b00 && haz) conf_cycles++;
        end
        checks++;
        if (conf_cycles != WIN) begin
            errors++;
            $display("FAIL R12: confirm cycles=%0d expected %0d", conf_cycles, WIN);
        end
        // R9 detect in stabilize, R5 critical escalation
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R5");
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R10");
        // R6 late stop
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
        for (int i = 0; i < WIN; i++) idle("R4");
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R6");
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R10");
        // R7 late continue beats critical
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
        for (int i = 0; i < WIN; i++) idle("R4");
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R7");
        // R4 verdict in last window cycle honoured
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
        for (int i = 0; i < WIN - 1; i++) idle("R4");
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R4");
        // R11 reset from full
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R11");
        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic r, d, v, c, k;
            r = ($urandom % 300) == 0;
            d = ($urandom % 8) == 0;
            v = ($urandom % 12) == 0;
            c = $urandom % 2;
            k = ($urandom % 6) == 0;
            step(r, d, v, c, k, r ? "R11" : tag_of(mst));
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule